// File: doc/BRIEF.md
# Two-Link Interleaved E1 System Bus Splitter

This block sits on the transmit-side system interface of a dual E1 framer. One serial bus carries both links byte-interleaved. It has a data line, a separate signaling line that runs in step with the data, and a frame pulse. All three are sampled on one high-rate bus clock, which runs at two or four clocks per bus bit. The block finds the frame start from the pulse and counts bits, timeslots and links. For every completed slot it hands the downstream framer one record. The record holds the data byte, the signaling nibble, the link it belongs to, the timeslot index and a frame-start marker.

After reset the block stays silent until the first active frame pulse. From then on it free-runs across frames, so a pulse is needed only when alignment is established or changes. A pulse that lands anywhere other than the expected frame boundary forces a fresh start from that point and raises a single-cycle realignment flag. Any partly received byte is dropped when this happens.

Top module: `e1_bus_demux`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `out_realign` are 0, and no record is produced until the first active frame pulse is seen.
- R2: The pulse is active-high when `cfg_fp_low` is 0 and active-low when it is 1. Only the clock on which it turns active starts a frame, and that clock is the first clock of bit 1 of link 0, timeslot 0. Holding the pulse active for several bits causes no further restart.
- R3: With `cfg_os4` = 0 each bus bit spans 2 clocks; with `cfg_os4` = 1 it spans 4 clocks. Only the value present on the last clock of the span is taken.
- R4: Bits arrive most significant first: the first bit of a slot appears on `out_byte[7]` and the eighth bit on `out_byte[0]`.
- R5: Slots alternate between links, first link 0 (`out_link` = 0) and then link 1. `out_slot` advances by one after each pair, giving 64 slots per frame with timeslots 0 to 31.
- R6: `out_sig` holds the signaling line values taken with bits 5 to 8 of the slot: bit 5 goes to `out_sig[3]` and bit 8 to `out_sig[0]`. Values on the signaling line during bits 1 to 4 have no effect.
- R7: `out_valid` is high for exactly one clock: the clock after the edge that samples the eighth bit of a slot.
- R8: `out_frame_start` is 1 on records with `out_slot` = 0 and 0 on every other record.
- R9: Without further pulses the position wraps after 512 bit periods to link 0, timeslot 0, and records continue.
- R10: A pulse edge seen while aligned but not at the frame boundary raises `out_realign` for one clock, the clock after that edge. A pulse at the boundary, or the first pulse after reset, raises nothing.
- R11: On a restart any partly received byte is discarded and produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplexed bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fp_low | input | 1 | Frame pulse polarity: 0 active-high, 1 active-low |
| cfg_os4 | input | 1 | Clocks per bus bit: 0 gives 2, 1 gives 4 (change only under reset) |
| bus_data | input | 1 | Serial interleaved data |
| bus_sig | input | 1 | Serial signaling, aligned to the data slots |
| bus_fp | input | 1 | Frame pulse marking link 0 timeslot 0 |
| out_valid | output | 1 | One-clock strobe for a completed slot |
| out_link | output | 1 | Link of the record |
| out_slot | output | 5 | Timeslot index 0 to 31 |
| out_byte | output | 8 | Data byte of the slot |
| out_sig | output | 4 | Signaling nibble of the slot |
| out_frame_start | output | 1 | Set on timeslot 0 records |
| out_realign | output | 1 | One-clock flag for an off-boundary pulse |

## Verification
Data bytes vary from slot to slot and include all-zero and all-one values. On every clock of a bit except the last, both the data and signaling lines carry the inverse of the bit. A block that samples at the wrong clock of the span therefore returns corrupted bytes. The signaling line carries unrelated values in the first four bits, which shows whether the nibble is taken from the right window. Several pulse patterns are used, and each tells apart a different behaviour:
- a frame with no pulse before lock, to check that the block stays silent;
- an aligned pulse, to check that no realignment is flagged;
- a pulse at a byte boundary in mid-frame;
- a pulse after three stray bits, to check the realignment flag and that the partial byte is dropped;
- a pulse held for three bits, to check that only its first edge restarts the frame.

Both oversampling rates and both pulse polarities are covered, and a reset in mid-stream checks that the block returns to its silent state.

// File: rtl/e1dm_pkg.sv
// Package: shared constants for the two-link interleaved bus splitter.
// Assumes an E1 frame of 32 timeslots per link and byte-wide slots.
package e1dm_pkg;
    localparam int E1_SLOTS    = 32;  // timeslots per link frame
    localparam int E1_LINKS    = 2;   // links sharing the bus
    localparam int SLOT_BITS   = 8;   // bits per slot
    localparam int SIG_NIBBLE  = 4;   // signaling bits per slot (tail of slot)
    localparam int OS_SLOW     = 2;   // clocks per bit, slower bus rate
    localparam int OS_FAST     = 4;   // clocks per bit, faster bus rate
endpackage

// File: rtl/e1dm_fp_edge.sv
// Module: frame pulse polarity correction and start-edge detection.
// Assumes: bus_fp is synchronous to clk; only the inactive-to-active
// transition marks a frame start, so a long pulse restarts once.
module e1dm_fp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_raw,
    input  logic fp_low,
    output logic pulse_edge
);
    logic fp_active;
    logic fp_prev_q;

    // Normalise the pulse to active-high.
    assign fp_active  = fp_raw ^ fp_low;
    // A start is the first clock the pulse is active.
    assign pulse_edge = fp_active & ~fp_prev_q;

    // Remember the previous pulse level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fp_prev_q <= 1'b0;
        else        fp_prev_q <= fp_active;
    end

    // R2: a held pulse yields a single start edge.
    p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_edge |=> !pulse_edge);
endmodule

// File: rtl/e1dm_frame_timer.sv
// Module: phase, bit and slot-position counters with lock and realignment.
// Assumes: os_sel is static outside reset. A start edge places the current
// clock at phase 0 of bit 0 of position 0; position bit 0 is the link.
module e1dm_frame_timer #(
    parameter int OS_LO       = 2,
    parameter int OS_HI       = 4,
    parameter int BYTE_W      = 8,
    parameter int FRAME_BYTES = 64,
    localparam int PH_W  = $clog2(OS_HI),
    localparam int BIT_W = $clog2(BYTE_W),
    localparam int POS_W = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_sel,
    input  logic             pulse_edge,
    output logic             locked,
    output logic             capture,
    output logic             byte_end,
    output logic [POS_W-1:0] pos,
    output logic             realign
);
    logic [PH_W-1:0]  phase_q;
    logic [BIT_W-1:0] bit_q;
    logic [POS_W-1:0] pos_q;
    logic             locked_q;
    logic             realign_q;
    logic [PH_W-1:0]  os_last;
    logic             at_boundary;
    logic             bit_last;
    logic             pos_last;

    // Last phase index of a bit for the selected bus rate.
    assign os_last     = os_sel ? PH_W'(OS_HI - 1) : PH_W'(OS_LO - 1);
    // Counters sit exactly at the start of a frame.
    assign at_boundary = (phase_q == '0) && (bit_q == '0) && (pos_q == '0);
    assign bit_last    = (bit_q == BIT_W'(BYTE_W - 1));
    assign pos_last    = (pos_q == POS_W'(FRAME_BYTES - 1));
    // Sample strobe: last clock of a bit span, not overridden by a restart.
    assign capture     = locked_q && !pulse_edge && (phase_q == os_last);
    assign byte_end    = capture && bit_last;

    assign locked  = locked_q;
    assign pos     = pos_q;
    assign realign = realign_q;

    // Advance the phase, bit and position counters; restart on a pulse edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= '0;
            bit_q     <= '0;
            pos_q     <= '0;
            locked_q  <= 1'b0;
            realign_q <= 1'b0;
        end else if (pulse_edge) begin
            phase_q   <= PH_W'(1);
            bit_q     <= '0;
            pos_q     <= '0;
            locked_q  <= 1'b1;
            realign_q <= locked_q && !at_boundary;
        end else begin
            realign_q <= 1'b0;
            if (locked_q) begin
                if (phase_q == os_last) begin
                    phase_q <= '0;
                    if (bit_last) begin
                        bit_q <= '0;
                        pos_q <= pos_last ? '0 : pos_q + POS_W'(1);
                    end else begin
                        bit_q <= bit_q + BIT_W'(1);
                    end
                end else begin
                    phase_q <= phase_q + PH_W'(1);
                end
            end
        end
    end

    // R3: the phase never leaves the span of the selected rate.
    p_phase_in_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= os_last);
    // R2: a start edge places the counters at the first bit of the frame.
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_edge |=> (locked_q && phase_q == PH_W'(1) && bit_q == '0 && pos_q == '0));
    // R9: the last slot of a frame is followed by position 0.
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && pos_last) |=> (pos_q == '0));
    // R10: the realignment flag lasts one clock.
    p_realign_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        realign_q |=> !realign_q);
endmodule

// File: rtl/e1dm_slot_assembler.sv
// Module: shifts in data and signaling bits and registers one record per slot.
// Assumes: capture marks each sampled bit (MSB first) and byte_end marks the
// eighth; pos is the slot position of the byte being completed.
module e1dm_slot_assembler #(
    parameter int BYTE_W = 8,
    parameter int SIG_W  = 4,
    parameter int LINK_W = 1,
    parameter int SLOT_W = 5,
    localparam int POS_W = LINK_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              byte_end,
    input  logic [POS_W-1:0]  pos,
    input  logic              data_bit,
    input  logic              sig_bit,
    output logic              rec_valid,
    output logic [LINK_W-1:0] rec_link,
    output logic [SLOT_W-1:0] rec_slot,
    output logic [BYTE_W-1:0] rec_byte,
    output logic [SIG_W-1:0]  rec_sig,
    output logic              rec_first
);
    logic [BYTE_W-2:0] data_sh_q;
    logic [SIG_W-2:0]  sig_sh_q;
    logic [SLOT_W-1:0] slot_of_pos;

    assign slot_of_pos = pos[POS_W-1:LINK_W];

    // Data shifter keeps the first seven bits of the slot, oldest at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_sh_q <= '0;
        else if (capture) data_sh_q <= {data_sh_q[BYTE_W-3:0], data_bit};
    end

    // Signaling shifter keeps only the most recent bits, so the slot tail wins.
    generate
        if (SIG_W > 2) begin : g_sig_wide
            always_ff @(posedge clk) begin
                if (!rst_n)       sig_sh_q <= '0;
                else if (capture) sig_sh_q <= {sig_sh_q[SIG_W-3:0], sig_bit};
            end
        end else begin : g_sig_narrow
            always_ff @(posedge clk) begin
                if (!rst_n)       sig_sh_q <= '0;
                else if (capture) sig_sh_q <= sig_bit;
            end
        end
    endgenerate

    // Register the completed record together with its one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_link  <= '0;
            rec_slot  <= '0;
            rec_byte  <= '0;
            rec_sig   <= '0;
            rec_first <= 1'b0;
        end else begin
            rec_valid <= byte_end;
            if (byte_end) begin
                rec_link  <= pos[LINK_W-1:0];
                rec_slot  <= slot_of_pos;
                rec_byte  <= {data_sh_q, data_bit};
                rec_sig   <= {sig_sh_q, sig_bit};
                rec_first <= (slot_of_pos == '0);
            end
        end
    end

    // R7: each record strobe lasts exactly one clock.
    p_valid_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);
endmodule

// File: rtl/e1_bus_demux.sv
// Module: top of the two-link interleaved E1 bus splitter.
// Assumes: link count is a power of two, cfg_os4 and cfg_fp_low are static
// outside reset, and all inputs are synchronous to clk.
module e1_bus_demux #(
    parameter int SLOTS   = e1dm_pkg::E1_SLOTS,
    parameter int LINKS   = e1dm_pkg::E1_LINKS,
    parameter int BYTE_W  = e1dm_pkg::SLOT_BITS,
    parameter int SIG_W   = e1dm_pkg::SIG_NIBBLE,
    parameter int OS_LO   = e1dm_pkg::OS_SLOW,
    parameter int OS_HI   = e1dm_pkg::OS_FAST,
    localparam int LINK_W      = $clog2(LINKS),
    localparam int SLOT_W      = $clog2(SLOTS),
    localparam int FRAME_BYTES = LINKS * SLOTS,
    localparam int POS_W       = LINK_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fp_low,
    input  logic              cfg_os4,
    input  logic              bus_data,
    input  logic              bus_sig,
    input  logic              bus_fp,
    output logic              out_valid,
    output logic [LINK_W-1:0] out_link,
    output logic [SLOT_W-1:0] out_slot,
    output logic [BYTE_W-1:0] out_byte,
    output logic [SIG_W-1:0]  out_sig,
    output logic              out_frame_start,
    output logic              out_realign
);
    logic             pulse_edge;
    logic             locked_w;
    logic             capture_w;
    logic             byte_end_w;
    logic [POS_W-1:0] pos_w;

    e1dm_fp_edge u_fp_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_raw     (bus_fp),
        .fp_low     (cfg_fp_low),
        .pulse_edge (pulse_edge)
    );

    e1dm_frame_timer #(
        .OS_LO       (OS_LO),
        .OS_HI       (OS_HI),
        .BYTE_W      (BYTE_W),
        .FRAME_BYTES (FRAME_BYTES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_sel     (cfg_os4),
        .pulse_edge (pulse_edge),
        .locked     (locked_w),
        .capture    (capture_w),
        .byte_end   (byte_end_w),
        .pos        (pos_w),
        .realign    (out_realign)
    );

    e1dm_slot_assembler #(
        .BYTE_W (BYTE_W),
        .SIG_W  (SIG_W),
        .LINK_W (LINK_W),
        .SLOT_W (SLOT_W)
    ) u_assembler (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture_w),
        .byte_end  (byte_end_w),
        .pos       (pos_w),
        .data_bit  (bus_data),
        .sig_bit   (bus_sig),
        .rec_valid (out_valid),
        .rec_link  (out_link),
        .rec_slot  (out_slot),
        .rec_byte  (out_byte),
        .rec_sig   (out_sig),
        .rec_first (out_frame_start)
    );

    // R1: no record appears while the frame timer has not locked.
    p_quiet_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_w |-> !out_valid);
    // R10: realignment is only flagged once aligned.
    p_realign_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_realign |-> locked_w);
endmodule

// File: tb/e1_bus_demux_bench.sv
module e1_bus_demux_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_fp_low, cfg_os4;
    logic       bus_data, bus_sig, bus_fp;
    logic       out_valid, out_link, out_frame_start, out_realign;
    logic [4:0] out_slot;
    logic [7:0] out_byte;
    logic [3:0] out_sig;

    always #2 clk = ~clk;   // 250 MHz

    e1_bus_demux u_e1_bus_demux (
        .clk(clk), .rst_n(rst_n), .cfg_fp_low(cfg_fp_low), .cfg_os4(cfg_os4),
        .bus_data(bus_data), .bus_sig(bus_sig), .bus_fp(bus_fp),
        .out_valid(out_valid), .out_link(out_link), .out_slot(out_slot),
        .out_byte(out_byte), .out_sig(out_sig),
        .out_frame_start(out_frame_start), .out_realign(out_realign)
    );

    typedef struct {
        logic [7:0] d;
        logic [3:0] s;
        logic       link;
        logic [4:0] slot;
        logic       fs;
        int         cyc;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    int   cyc = 0;
    int   os = 2;
    int   pos = 0;
    bit   exp_locked = 0, partial = 0;
    int   exp_realigns = 0, seen_realigns = 0, exp_rcyc = -1;
    int   seen_valid = 0;
    bit   prev_valid = 0, prev_realign = 0, done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop expected records and compare as the design emits them.
    always @(negedge clk) begin
        if (out_valid) begin
            seen_valid++;
            if (prev_valid) chk("R7 strobe width", 32'd1, 32'd0);
            if (q.size() == 0) begin
                chk("R1/R11 unexpected record", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R4/R3 data byte", {24'd0, out_byte}, {24'd0, e.d});
                chk("R6 signaling nibble", {28'd0, out_sig}, {28'd0, e.s});
                chk("R5 link", {31'd0, out_link}, {31'd0, e.link});
                chk("R5/R9 slot", {27'd0, out_slot}, {27'd0, e.slot});
                chk("R8 frame start", {31'd0, out_frame_start}, {31'd0, e.fs});
                chk("R7 strobe timing", cyc, e.cyc);
            end
        end
        if (out_realign) begin
            seen_realigns++;
            if (prev_realign) chk("R10 realign width", 32'd1, 32'd0);
            chk("R10 realign timing", cyc, exp_rcyc);
        end
        prev_valid   = out_valid;
        prev_realign = out_realign;
    end

    function automatic logic [7:0] pat(input int seed, input int b);
        if (b % 16 == 3)      pat = 8'hFF;
        else if (b % 16 == 7) pat = 8'h00;
        else                  pat = 8'((b * 37 + seed * 11) ^ 8'hA5);
    endfunction

    // Driver: one slot, glitching all but the last clock of each bit.
    task automatic send_byte(input logic [7:0] d, input logic [7:0] s, input int fp_len);
        logic       lk;
        logic [4:0] sl;
        if (fp_len > 0) begin
            if (exp_locked && (pos != 0 || partial)) exp_realigns++;
            exp_locked = 1;
            pos = 0;
            partial = 0;
        end
        lk = pos[0];
        sl = 5'(pos / 2);
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < os; p++) begin
                @(negedge clk);
                bus_data = (p == os - 1) ? d[7-i] : ~d[7-i];
                bus_sig  = (p == os - 1) ? s[7-i] : ~s[7-i];
                bus_fp   = (i < fp_len) ^ cfg_fp_low;
                if (fp_len > 0 && i == 0 && p == 0) exp_rcyc = cyc + 1;
                if (i == 7 && p == os - 1 && exp_locked) begin
                    exp_t e;
                    e.d = d; e.s = s[3:0]; e.link = lk; e.slot = sl;
                    e.fs = (sl == 5'd0); e.cyc = cyc + 1;
                    q.push_back(e);
                end
            end
        end
        if (exp_locked) pos = (pos + 1) % 64;
    endtask

    task automatic send_run(input int n, input int seed, input bit with_fp, input int fp_len);
        for (int b = 0; b < n; b++)
            send_byte(pat(seed, b), pat(seed + 3, b), (with_fp && b == 0) ? fp_len : 0);
    endtask

    task automatic send_bits(input int n);
        for (int i = 0; i < n; i++)
            for (int p = 0; p < os; p++) begin
                @(negedge clk);
                bus_data = i[0]; bus_sig = ~i[0]; bus_fp = cfg_fp_low;
            end
        if (exp_locked) partial = 1;
    endtask

    task automatic do_reset(input bit os4, input bit low);
        @(negedge clk);
        rst_n = 1'b0; cfg_os4 = os4; cfg_fp_low = low; bus_fp = low;
        bus_data = 1'b0; bus_sig = 1'b0;
        os = os4 ? 4 : 2;
        exp_locked = 0; pos = 0; partial = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1 realign after reset", {31'd0, out_realign}, 32'd0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("watchdog expired", 32'd1, 32'd0);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; cfg_os4 = 1'b0; cfg_fp_low = 1'b0;
        bus_data = 1'b0; bus_sig = 1'b0; bus_fp = 1'b0;
        do_reset(1'b0, 1'b0);

        // R1: traffic without a pulse gives nothing.
        send_run(16, 1, 1'b0, 0);
        repeat (4) @(negedge clk);
        chk("R1 silent before pulse", seen_valid, 0);

        // R2, R5, R9: aligned frame, free-running frame, aligned pulse again.
        send_run(64, 2, 1'b1, 1);
        send_run(64, 5, 1'b0, 0);
        send_run(64, 9, 1'b1, 1);
        chk("R10 no realign on boundary", seen_realigns, 0);

        // R10: pulse at a mid-frame byte boundary.
        send_run(10, 4, 1'b1, 1);
        send_run(20, 6, 1'b1, 1);
        // R11: stray bits, then a pulse; the partial byte must vanish.
        send_bits(3);
        send_run(8, 7, 1'b1, 1);
        // R2: pulse held for three bits restarts only once.
        send_run(64, 8, 1'b1, 3);
        repeat (4) @(negedge clk);
        chk("R10 realign count", seen_realigns, exp_realigns);
        chk("R11 queue drained", q.size(), 0);

        // R3, R2: fast bus with an active-low pulse, mid-stream reset.
        do_reset(1'b1, 1'b1);
        seen_valid = 0;
        send_run(8, 10, 1'b0, 0);
        repeat (4) @(negedge clk);
        chk("R1 silent after reset", seen_valid, 0);
        send_run(64, 11, 1'b1, 1);
        send_run(64, 12, 1'b0, 0);
        send_run(4, 13, 1'b1, 1);
        repeat (8) @(negedge clk);
        chk("R10 realign count final", seen_realigns, exp_realigns);
        chk("R9 queue drained", q.size(), 0);

        done = 1;
        finish_run();
    end
endmodule